// File: doc/BRIEF.md
# Prescaled Timestamp Counter with Rollover Interrupt

This block keeps a 16-bit timestamp that advances on the interface clock. A 24-bit programmable divider sets the advance rate. A single control bit starts and stops the count. Stopping it clears both the timestamp and the divider, so a restart always begins from zero. The current timestamp is exported on its own port, so a neighbouring protocol core can stamp frames with it.

Every wrap of the timestamp from 0xFFFF to 0x0000 is a rollover event. Software can also raise a rollover event by writing the status address. Each event does four things:
- sets a raw status bit;
- increments a saturating 8-bit pending count;
- fires a one-clock interrupt pulse;
- through an enable bit, drives a level interrupt.

Clearing the status decrements the pending count. An end-of-interrupt write re-fires the pulse while events are still pending, so a pulse-driven handler can drain a backlog one event at a time.

Two state machines carry the behaviour:
- **Counter machine.** `CNT_OFF` goes to `CNT_RUN` on a control write with bit 0 set. `CNT_RUN` goes to `CNT_OFF` on a control write with bit 0 clear. In `CNT_OFF` the timestamp and the divider are held at zero.
- **Pending machine.** `PND_EMPTY` goes to `PND_HOLD` on an event. `PND_HOLD` goes to `PND_FULL` when an event brings the count to 255. `PND_HOLD` goes back to `PND_EMPTY` when a clear brings the count to 0. `PND_FULL` goes to `PND_HOLD` on a clear. An event and a clear in the same cycle cause no transition.

Top module: `tstamp_irq_top`

## Requirements
- R1: After reset, `ts_value`, `irq_level` and `irq_pulse` are 0, and every register reads 0.
- R2: While control bit 0 (address 0x0) is 1, `ts_value` advances by one every P+1 clocks, where P is the prescale register (address 0x1). P=0 advances it every clock. The first advance comes P+1 clocks after the enabling write.
- R3: Writing control bit 0 as 0 sets `ts_value` and the divider to 0 at that clock edge, and they stay 0 while the counter is off. Control reads back bit 0 as the run state, and the timestamp reads at address 0x2.
- R4: A wrap of `ts_value` from 0xFFFF to 0 sets raw status (bit 0 at address 0x3) and increments the pending count (address 0x9).
- R5: A write to address 0x3 with bit 0 = 1 is an injected event with the same effect as a wrap. Writing bit 0 = 0 there does nothing.
- R6: A write with bit 0 = 1 to address 0x5 sets the interrupt enable. A write with bit 0 = 1 to address 0x6 clears it. Address 0x5 reads the enable bit.
- R7: `irq_level` is 1 exactly when raw status and enable are both 1, and address 0x7 reads the same value.
- R8: A write with bit 0 = 1 to address 0x4 clears raw status and decrements the pending count, which stays at 0 if already 0. If an event occurs in the same cycle, status ends set and the count is unchanged.
- R9: The pending count saturates at 255.
- R10: `irq_pulse` is high for one clock after each event. A write of any value to address 0x8 pulses it only if the pending count is nonzero.
- R11: The prescale register holds and reads back all 24 bits, and unmapped addresses read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Interface clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 4 | Register word address |
| wdata | input | 24 | Write data |
| rdata | output | 24 | Read data for `addr`, combinational |
| ts_value | output | 16 | Current timestamp |
| irq_level | output | 1 | Level interrupt (status AND enable) |
| irq_pulse | output | 1 | One-clock interrupt pulse |

## Verification
A divider that is not cleared on disable shows up as a timestamp that advances early, within P+1 clocks of re-enabling. A pending count that is stuck or has wrapped shows up at the next end-of-interrupt write: the pulse appears or is missing one clock after that write, and address 0x9 reads the wrong value at once. A wrong status or enable bit appears on `irq_level` in the clock after the write that set it. Clearing status in the same cycle as a real wrap exercises the collision rule, with the result readable in the following cycles.

// File: rtl/tsi_pkg.sv
package tsi_pkg;
    localparam int TS_W   = 16;
    localparam int PRE_W  = 24;
    localparam int PEND_W = 8;
    localparam int ADDR_W = 4;

    typedef enum logic [ADDR_W-1:0] {
        ADDR_CTRL    = 4'h0,
        ADDR_PRESC   = 4'h1,
        ADDR_TSTAMP  = 4'h2,
        ADDR_STAT    = 4'h3,
        ADDR_STATCLR = 4'h4,
        ADDR_IEN     = 4'h5,
        ADDR_IENCLR  = 4'h6,
        ADDR_LEVEL   = 4'h7,
        ADDR_EOI     = 4'h8,
        ADDR_PEND    = 4'h9
    } reg_addr_e;

    typedef enum logic {
        CNT_OFF = 1'b0,
        CNT_RUN = 1'b1
    } cnt_state_e;

    typedef enum logic [1:0] {
        PND_EMPTY = 2'd0,
        PND_HOLD  = 2'd1,
        PND_FULL  = 2'd2
    } pnd_state_e;

    typedef struct packed {
        logic ctrl_wr;
        logic presc_wr;
        logic stat_set;
        logic stat_clr;
        logic ien_set;
        logic ien_clr;
        logic eoi;
    } bus_stb_t;
endpackage

// File: rtl/tsi_regbus.sv
module tsi_regbus
    import tsi_pkg::*;
#(
    parameter int DATA_W = 24,
    parameter int TS_W   = 16,
    parameter int PEND_W = 8
) (
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              run,
    input  logic [DATA_W-1:0] presc,
    input  logic [TS_W-1:0]   ts,
    input  logic              status,
    input  logic              ien,
    input  logic              level,
    input  logic [PEND_W-1:0] pend,
    output bus_stb_t          stb,
    output logic [DATA_W-1:0] rdata
);
    logic set_bit;
    assign set_bit = wdata[0];

    always_comb begin
        stb = '0;
        if (wr_en) begin
            case (addr)
                ADDR_CTRL:    stb.ctrl_wr  = 1'b1;
                ADDR_PRESC:   stb.presc_wr = 1'b1;
                ADDR_STAT:    stb.stat_set = set_bit;
                ADDR_STATCLR: stb.stat_clr = set_bit;
                ADDR_IEN:     stb.ien_set  = set_bit;
                ADDR_IENCLR:  stb.ien_clr  = set_bit;
                ADDR_EOI:     stb.eoi      = 1'b1;
                default:      stb = '0;
            endcase
        end
    end

    always_comb begin
        rdata = '0;
        case (addr)
            ADDR_CTRL:   rdata = DATA_W'(run);
            ADDR_PRESC:  rdata = presc;
            ADDR_TSTAMP: rdata = DATA_W'(ts);
            ADDR_STAT:   rdata = DATA_W'(status);
            ADDR_IEN:    rdata = DATA_W'(ien);
            ADDR_LEVEL:  rdata = DATA_W'(level);
            ADDR_PEND:   rdata = DATA_W'(pend);
            default:     rdata = '0;
        endcase
    end
endmodule

// File: rtl/tsi_prescale_ctr.sv
module tsi_prescale_ctr
    import tsi_pkg::*;
#(
    parameter int TS_W  = 16,
    parameter int PRE_W = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ctrl_wr,
    input  logic             ctrl_val,
    input  logic             presc_wr,
    input  logic [PRE_W-1:0] presc_wdata,
    output logic             run,
    output logic [PRE_W-1:0] presc,
    output logic [TS_W-1:0]  ts,
    output logic             rollover
);
    localparam logic [TS_W-1:0] TS_MAX = {TS_W{1'b1}};

    cnt_state_e       state_q, state_d;
    logic [PRE_W-1:0] presc_q;
    logic [PRE_W-1:0] div_q;
    logic [TS_W-1:0]  ts_q;
    logic             counting;
    logic             tick;

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            CNT_OFF: if (ctrl_wr && ctrl_val)  state_d = CNT_RUN;
            CNT_RUN: if (ctrl_wr && !ctrl_val) state_d = CNT_OFF;
            default: state_d = CNT_OFF;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= CNT_OFF;
        else        state_q <= state_d;
    end

    // output decode
    always_comb begin
        counting = 1'b0;
        unique case (state_q)
            CNT_OFF: counting = 1'b0;
            CNT_RUN: counting = (state_d == CNT_RUN);
            default: counting = 1'b0;
        endcase
    end

    assign tick     = counting && (div_q >= presc_q);
    assign rollover = tick && (ts_q == TS_MAX);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        presc_q <= '0;
        else if (presc_wr) presc_q <= presc_wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            div_q <= '0;
            ts_q  <= '0;
        end else if (state_d == CNT_OFF) begin
            div_q <= '0;
            ts_q  <= '0;
        end else if (tick) begin
            div_q <= '0;
            ts_q  <= ts_q + 1'b1;
        end else if (counting) begin
            div_q <= div_q + 1'b1;
        end
    end

    assign run   = (state_q == CNT_RUN);
    assign presc = presc_q;
    assign ts    = ts_q;
endmodule

// File: rtl/tsi_irq_ctrl.sv
module tsi_irq_ctrl
    import tsi_pkg::*;
#(
    parameter int PEND_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              roll_evt,
    input  logic              inj_evt,
    input  logic              stat_clr,
    input  logic              ien_set,
    input  logic              ien_clr,
    input  logic              eoi,
    output logic              status,
    output logic              ien,
    output logic              level,
    output logic [PEND_W-1:0] pend,
    output logic              irq_pulse
);
    localparam logic [PEND_W-1:0] PEND_MAX  = {PEND_W{1'b1}};
    localparam logic [PEND_W-1:0] PEND_LAST = PEND_MAX - 1'b1;
    localparam logic [PEND_W-1:0] PEND_ONE  = {{(PEND_W-1){1'b0}}, 1'b1};

    pnd_state_e        pst_q, pst_d;
    logic [PEND_W-1:0] cnt_q, cnt_d;
    logic              evt;
    logic              up, down;
    logic              eoi_fire;
    logic              status_q, ien_q, pulse_q;

    assign evt  = roll_evt | inj_evt;
    assign up   = evt && !stat_clr;
    assign down = stat_clr && !evt;

    // next-state logic for the pending machine
    always_comb begin
        pst_d = pst_q;
        cnt_d = cnt_q;
        unique case (pst_q)
            PND_EMPTY: begin
                if (up) begin
                    cnt_d = cnt_q + 1'b1;
                    pst_d = PND_HOLD;
                end
            end
            PND_HOLD: begin
                if (up) begin
                    cnt_d = cnt_q + 1'b1;
                    if (cnt_q == PEND_LAST) pst_d = PND_FULL;
                end else if (down) begin
                    cnt_d = cnt_q - 1'b1;
                    if (cnt_q == PEND_ONE) pst_d = PND_EMPTY;
                end
            end
            PND_FULL: begin
                if (down) begin
                    cnt_d = cnt_q - 1'b1;
                    pst_d = PND_HOLD;
                end
            end
            default: begin
                pst_d = PND_EMPTY;
                cnt_d = '0;
            end
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pst_q <= PND_EMPTY;
            cnt_q <= '0;
        end else begin
            pst_q <= pst_d;
            cnt_q <= cnt_d;
        end
    end

    // output decode
    always_comb begin
        eoi_fire = 1'b0;
        unique case (pst_q)
            PND_EMPTY: eoi_fire = 1'b0;
            PND_HOLD:  eoi_fire = eoi;
            PND_FULL:  eoi_fire = eoi;
            default:   eoi_fire = 1'b0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            status_q <= 1'b0;
            ien_q    <= 1'b0;
            pulse_q  <= 1'b0;
        end else begin
            if (evt)           status_q <= 1'b1;
            else if (stat_clr) status_q <= 1'b0;
            if (ien_set)       ien_q <= 1'b1;
            else if (ien_clr)  ien_q <= 1'b0;
            pulse_q <= evt || eoi_fire;
        end
    end

    assign status    = status_q;
    assign ien       = ien_q;
    assign level     = status_q & ien_q;
    assign pend      = cnt_q;
    assign irq_pulse = pulse_q;
endmodule

// File: rtl/tstamp_irq_top.sv
module tstamp_irq_top
    import tsi_pkg::*;
#(
    parameter int TS_W   = tsi_pkg::TS_W,
    parameter int PRE_W  = tsi_pkg::PRE_W,
    parameter int PEND_W = tsi_pkg::PEND_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [3:0]        addr,
    input  logic [PRE_W-1:0]  wdata,
    output logic [PRE_W-1:0]  rdata,
    output logic [TS_W-1:0]   ts_value,
    output logic              irq_level,
    output logic              irq_pulse
);
    localparam int DATA_W = PRE_W;

    bus_stb_t          stb;
    logic              cnt_run;
    logic [PRE_W-1:0]  presc_val;
    logic              roll_evt;
    logic              inj_evt;
    logic              clr_evt;
    logic              eoi_wr;
    logic              stat_bit;
    logic              ien_bit;
    logic [PEND_W-1:0] pend_cnt;

    assign inj_evt = stb.stat_set;
    assign clr_evt = stb.stat_clr;
    assign eoi_wr  = stb.eoi;

    tsi_regbus #(.DATA_W(DATA_W), .TS_W(TS_W), .PEND_W(PEND_W)) u_bus (
        .wr_en  (wr_en),
        .addr   (addr),
        .wdata  (wdata),
        .run    (cnt_run),
        .presc  (presc_val),
        .ts     (ts_value),
        .status (stat_bit),
        .ien    (ien_bit),
        .level  (irq_level),
        .pend   (pend_cnt),
        .stb    (stb),
        .rdata  (rdata)
    );

    tsi_prescale_ctr #(.TS_W(TS_W), .PRE_W(PRE_W)) u_ctr (
        .clk         (clk),
        .rst_n       (rst_n),
        .ctrl_wr     (stb.ctrl_wr),
        .ctrl_val    (wdata[0]),
        .presc_wr    (stb.presc_wr),
        .presc_wdata (wdata),
        .run         (cnt_run),
        .presc       (presc_val),
        .ts          (ts_value),
        .rollover    (roll_evt)
    );

    tsi_irq_ctrl #(.PEND_W(PEND_W)) u_irq (
        .clk       (clk),
        .rst_n     (rst_n),
        .roll_evt  (roll_evt),
        .inj_evt   (inj_evt),
        .stat_clr  (clr_evt),
        .ien_set   (stb.ien_set),
        .ien_clr   (stb.ien_clr),
        .eoi       (eoi_wr),
        .status    (stat_bit),
        .ien       (ien_bit),
        .level     (irq_level),
        .pend      (pend_cnt),
        .irq_pulse (irq_pulse)
    );
endmodule

// File: rtl/tsi_checker.sv
module tsi_checker #(
    parameter int TS_W   = 16,
    parameter int PEND_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic [TS_W-1:0]   ts,
    input logic              run,
    input logic              roll,
    input logic              inj,
    input logic              clr,
    input logic              eoi,
    input logic              status,
    input logic [PEND_W-1:0] pend,
    input logic              irq_pulse
);
    logic inc;
    assign inc = roll | inj;

    p_ts_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (ts != $past(ts)) |-> (ts == $past(ts) + 1'b1 || ts == '0));

    p_off_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !run |-> (ts == '0));

    p_roll_status_r4: assert property (@(posedge clk) disable iff (!rst_n)
        roll |=> status);

    p_inc_count_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (inc && !clr && pend != '1) |=> (pend == $past(pend) + 1'b1));

    p_clr_dec_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && !inc && pend != '0) |=> (pend == $past(pend) - 1'b1));

    p_both_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && inc) |=> $stable(pend));

    p_no_overflow_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (pend == '1 && inc && !clr) |=> (pend == '1));

    p_eoi_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (eoi && pend != '0) |=> irq_pulse);

    p_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!inc && !(eoi && pend != '0)) |=> !irq_pulse);
endmodule

bind tstamp_irq_top tsi_checker #(.TS_W(TS_W), .PEND_W(PEND_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .ts        (ts_value),
    .run       (cnt_run),
    .roll      (roll_evt),
    .inj       (inj_evt),
    .clr       (clr_evt),
    .eoi       (eoi_wr),
    .status    (stat_bit),
    .pend      (pend_cnt),
    .irq_pulse (irq_pulse)
);

// File: tb/tb_tstamp_irq_top.sv
module tb_tstamp_irq_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [3:0]  addr = 4'h0;
    logic [23:0] wdata = 24'h0;
    logic [23:0] rdata;
    logic [15:0] ts_value;
    logic        irq_level;
    logic        irq_pulse;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    tstamp_irq_top dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .rdata(rdata), .ts_value(ts_value), .irq_level(irq_level), .irq_pulse(irq_pulse)
    );

    typedef struct packed {
        logic        is_rd;
        logic [3:0]  a;
        logic [23:0] d;
        logic [23:0] exp;
        logic [3:0]  rq;
    } vec_t;

    localparam int N_VEC = 31;
    localparam vec_t VECS [N_VEC] = '{
        '{1'b1, 4'h5, 24'h0, 24'h0, 4'd6},        // R6 enable clear after reset
        '{1'b1, 4'h3, 24'h0, 24'h0, 4'd1},        // R1 status clear after reset
        '{1'b0, 4'h3, 24'h1, 24'h0, 4'd5},        // R5 inject
        '{1'b1, 4'h3, 24'h0, 24'h1, 4'd5},
        '{1'b1, 4'h9, 24'h0, 24'h1, 4'd5},
        '{1'b1, 4'h7, 24'h0, 24'h0, 4'd7},        // R7 not enabled
        '{1'b0, 4'h5, 24'h0, 24'h0, 4'd6},        // R6 bit0=0 ignored
        '{1'b1, 4'h5, 24'h0, 24'h0, 4'd6},
        '{1'b0, 4'h5, 24'h1, 24'h0, 4'd6},
        '{1'b1, 4'h5, 24'h0, 24'h1, 4'd6},
        '{1'b1, 4'h7, 24'h0, 24'h1, 4'd7},        // R7 level set
        '{1'b0, 4'h3, 24'h1, 24'h0, 4'd5},
        '{1'b1, 4'h9, 24'h0, 24'h2, 4'd5},
        '{1'b0, 4'h4, 24'h1, 24'h0, 4'd8},        // R8 clear
        '{1'b1, 4'h3, 24'h0, 24'h0, 4'd8},
        '{1'b1, 4'h9, 24'h0, 24'h1, 4'd8},
        '{1'b1, 4'h7, 24'h0, 24'h0, 4'd7},
        '{1'b0, 4'h6, 24'h1, 24'h0, 4'd6},
        '{1'b1, 4'h5, 24'h0, 24'h0, 4'd6},
        '{1'b0, 4'h4, 24'h1, 24'h0, 4'd8},
        '{1'b1, 4'h9, 24'h0, 24'h0, 4'd8},
        '{1'b0, 4'h4, 24'h1, 24'h0, 4'd8},        // R8 floor at zero
        '{1'b1, 4'h9, 24'h0, 24'h0, 4'd8},
        '{1'b0, 4'h1, 24'h123456, 24'h0, 4'd11},  // R11 prescale readback
        '{1'b1, 4'h1, 24'h0, 24'h123456, 4'd11},
        '{1'b0, 4'h1, 24'hFFFFFF, 24'h0, 4'd11},
        '{1'b1, 4'h1, 24'h0, 24'hFFFFFF, 4'd11},
        '{1'b0, 4'h1, 24'h0, 24'h0, 4'd11},
        '{1'b1, 4'h1, 24'h0, 24'h0, 4'd11},
        '{1'b1, 4'hF, 24'h0, 24'h0, 4'd11},       // R11 unmapped
        '{1'b1, 4'h2, 24'h0, 24'h0, 4'd3}         // R3 timestamp idle at zero
    };

    task automatic chk(input string tag, input logic [23:0] act, input logic [23:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [23:0] d);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0; wdata = 24'h0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [23:0] v);
        addr = a;
        #1 v = rdata;
        @(negedge clk);
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog R1 actual=timeout expected=completion");
            finish_run();
        end
    end

    initial begin
        logic [23:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 ts_value", 24'(ts_value), 24'h0);
        chk("R1 irq_level", 24'(irq_level), 24'h0);
        chk("R1 irq_pulse", 24'(irq_pulse), 24'h0);
        rd(4'h9, v); chk("R1 pend", v, 24'h0);
        rd(4'h0, v); chk("R1 ctrl", v, 24'h0);

        for (int i = 0; i < N_VEC; i++) begin
            if (VECS[i].is_rd) begin
                rd(VECS[i].a, v);
                chk($sformatf("R%0d vec%0d", VECS[i].rq, i), v, VECS[i].exp);
            end else begin
                wr(VECS[i].a, VECS[i].d);
            end
        end

        // R10 pulses: event, EOI with pending, EOI with none
        wr(4'h3, 24'h1);
        chk("R10 pulse on inject", 24'(irq_pulse), 24'h1);
        @(negedge clk);
        chk("R10 pulse one clock", 24'(irq_pulse), 24'h0);
        wr(4'h8, 24'h0);
        chk("R10 eoi pulse pending", 24'(irq_pulse), 24'h1);
        @(negedge clk);
        chk("R10 eoi pulse width", 24'(irq_pulse), 24'h0);
        wr(4'h4, 24'h1);
        wr(4'h8, 24'h0);
        chk("R10 eoi no pending", 24'(irq_pulse), 24'h0);
        wr(4'h3, 24'h0);
        rd(4'h9, v); chk("R5 bit0=0 ignored", v, 24'h0);

        // R9 saturation
        for (int k = 0; k < 300; k++) wr(4'h3, 24'h1);
        rd(4'h9, v); chk("R9 saturate", v, 24'd255);
        wr(4'h4, 24'h1);
        rd(4'h9, v); chk("R9 leave full", v, 24'd254);
        for (int k = 0; k < 254; k++) wr(4'h4, 24'h1);
        rd(4'h9, v); chk("R8 drained", v, 24'h0);

        // R2 prescale 3
        wr(4'h1, 24'd3);
        wr(4'h0, 24'h1);
        repeat (10) @(negedge clk);
        chk("R2 p3 after 10", 24'(ts_value), 24'd2);
        repeat (3) @(negedge clk);
        chk("R2 p3 after 13", 24'(ts_value), 24'd3);
        // R3 disable zeroes timestamp and divider
        wr(4'h0, 24'h0);
        chk("R3 ts zeroed", 24'(ts_value), 24'h0);
        rd(4'h0, v); chk("R3 ctrl off", v, 24'h0);
        repeat (4) @(negedge clk);
        chk("R3 stays zero", 24'(ts_value), 24'h0);
        wr(4'h0, 24'h1);
        repeat (3) @(negedge clk);
        chk("R3 divider restarted", 24'(ts_value), 24'h0);
        @(negedge clk);
        chk("R2 first step P+1", 24'(ts_value), 24'h1);
        wr(4'h0, 24'h0);

        // R2 prescale 0
        wr(4'h1, 24'h0);
        wr(4'h0, 24'h1);
        repeat (5) @(negedge clk);
        chk("R2 p0 every clock", 24'(ts_value), 24'd5);
        wr(4'h0, 24'h0);

        // R4/R8 rollover colliding with a clear
        wr(4'h3, 24'h1);
        wr(4'h3, 24'h1);
        wr(4'h5, 24'h1);
        wr(4'h0, 24'h1);
        repeat (65535) @(negedge clk);
        chk("R4 ts at max", 24'(ts_value), 24'hFFFF);
        wr(4'h4, 24'h1);
        chk("R4 wrapped", 24'(ts_value), 24'h0);
        chk("R10 pulse on wrap", 24'(irq_pulse), 24'h1);
        chk("R7 level port", 24'(irq_level), 24'h1);
        rd(4'h3, v); chk("R8 set wins", v, 24'h1);
        rd(4'h9, v); chk("R8 count held", v, 24'd2);

        // R4 plain rollover
        repeat (65533) @(negedge clk);
        chk("R4 ts at max again", 24'(ts_value), 24'hFFFF);
        @(negedge clk);
        chk("R4 wrapped again", 24'(ts_value), 24'h0);
        chk("R10 pulse on second wrap", 24'(irq_pulse), 24'h1);
        rd(4'h9, v); chk("R4 count up", v, 24'd3);

        done = 1'b1;
        finish_run();
    end
endmodule